// File: doc/BRIEF.md
# Stop-Mode Wakeup Clock Source Selector

This block chooses the clock that steps the processor core when it comes out of stop mode. Entering stop turns the crystal off. A wake event turns the crystal back on and starts a startup counter that counts crystal ticks. If the ring-start option is enabled, the core resumes at once on a ring-oscillator tick. When the count is complete, the core moves over to the crystal tick. If the option is off, the core stays frozen until the count is complete.

Both oscillators are modelled as single-cycle enable pulses in one clock domain. The block drives a gated core tick, a watchdog tick, a crystal-enable output, a status flag that is high while the ring supplies the core, and a lock on the clock-divide code. The divide code is forced to divide-by-1 (code 2'b10) while the ring is in use.

Top module: `wake_clk_sel`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in the crystal run state. `xtalOn`=1, `onRing`=0, `divLock`=0, `divCode`=2'b10, and `coreTick` equals `xtalTick`.
- R2: A `stopReq` pulse in the run state moves the block to stopped from the next cycle. While stopped, `xtalOn`, `coreTick` and `wdtTick` are all 0. A `stopReq` that arrives while already stopped has no effect.
- R3: A `stopExit` pulse while stopped sets `xtalOn` to 1 in the next cycle and clears the startup counter. The wait ends on the cycle that carries the `STARTUP_CNT`-th `xtalTick` (65,536 by default). A `stopExit` in any other state is ignored.
- R4: If `ringSelEn` is 0 when the wake event arrives, `coreTick` stays 0 for the whole count. From the cycle after the final counted tick, `coreTick` equals `xtalTick`.
- R5: If `ringSelEn` is 1 when the wake event arrives, `onRing` is 1 from the next cycle and `coreTick` equals `ringTick` for the whole count. The ring can only be entered from the stopped state.
- R6: When the count is complete on the ring path, the core stays on `ringTick` until a cycle in which `xtalTick` and `ringTick` are both 0. In the cycle after that, `onRing` is 0 and `coreTick` follows `xtalTick`.
- R7: `divLock` equals `onRing`. Entering the ring loads `divCode` with 2'b10. While `onRing` is 1, `divCode` reads 2'b10 and `divWr` is ignored.
- R8: `wdtTick` equals `xtalTick` whenever `xtalOn` is 1 and is 0 otherwise. It never follows `ringTick`.
- R9: A `stopReq` during the startup count or the handover wait returns the block to stopped in the next cycle. The next wake starts a fresh count from zero.
- R10: While `onRing` is 0, a `divWr` pulse loads `divReq` into `divCode` from the next cycle. On a wake into the ring in the same cycle, the forced 2'b10 takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xtalTick | input | 1 | Crystal oscillator tick enable |
| ringTick | input | 1 | Ring oscillator tick enable |
| stopReq | input | 1 | Request to enter stop mode |
| stopExit | input | 1 | Wake event that ends stop mode |
| ringSelEn | input | 1 | Run on the ring clock during crystal startup |
| divWr | input | 1 | Write strobe for the divide code |
| divReq | input | 2 | Requested divide code |
| coreTick | output | 1 | Tick enable delivered to the core |
| wdtTick | output | 1 | Tick enable for the watchdog (crystal only) |
| xtalOn | output | 1 | Crystal oscillator enable |
| onRing | output | 1 | Status: ring clock is the system clock |
| divLock | output | 1 | Divide code is locked |
| divCode | output | 2 | Current clock-divide code |

## Verification
The assertions assume that `xtalTick` and `ringTick` are one-cycle enables sampled in the block clock domain. They assume that `stopReq` and `stopExit` are treated as levels sampled at each edge, with no further handshake. The handover check also relies on both tick inputs being low at times. The random stimulus draws each tick independently with probability one half, so the both-low cycles it needs happen often, and it keeps stop and wake pulses sparse so that full counts finish. Directed sequences force a stop in the middle of a count, a wake while both ticks stay high for many cycles, and a divide write in the same cycle as a wake into the ring.

// File: rtl/wake_clk_pkg.sv
package wake_clk_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_STOP   = 3'd1,
    ST_HOLD   = 3'd2,
    ST_RING   = 3'd3,
    ST_SWITCH = 3'd4
  } wakeState_t;

  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic forceDiv1;
    logic divWrEn;
  } wakeStrobe_t;

  localparam logic [1:0] DIV_BY1 = 2'b10;
endpackage

// File: rtl/wake_clk_ctrl.sv
module wake_clk_ctrl
  import wake_clk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        xtalTick,
  input  logic        ringTick,
  input  logic        stopReq,
  input  logic        stopExit,
  input  logic        ringSelEn,
  input  logic        divWr,
  input  logic        cntDone,
  output wakeStrobe_t strobe,
  output logic        coreTick,
  output logic        onRing,
  output logic        xtalOn
);
  wakeState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:    if (stopReq) stateNext = ST_STOP;
      ST_STOP:   if (stopExit) stateNext = ringSelEn ? ST_RING : ST_HOLD;
      ST_HOLD:   if (stopReq) stateNext = ST_STOP;
                 else if (cntDone) stateNext = ST_RUN;
      ST_RING:   if (stopReq) stateNext = ST_STOP;
                 else if (cntDone) stateNext = ST_SWITCH;
      ST_SWITCH: if (stopReq) stateNext = ST_STOP;
                 else if (!xtalTick && !ringTick) stateNext = ST_RUN;
      default:   stateNext = ST_RUN;
    endcase
  end

  always_comb begin
    onRing = (state == ST_RING) || (state == ST_SWITCH);
    xtalOn = (state != ST_STOP);
    unique case (state)
      ST_RUN:             coreTick = xtalTick;
      ST_RING, ST_SWITCH: coreTick = ringTick;
      default:            coreTick = 1'b0;
    endcase
    strobe.cntClr    = (state == ST_STOP) && stopExit;
    strobe.cntEn     = ((state == ST_HOLD) || (state == ST_RING)) && !stopReq;
    strobe.forceDiv1 = (state == ST_STOP) && stopExit && ringSelEn;
    strobe.divWrEn   = divWr && !onRing;
  end
endmodule

// File: rtl/wake_clk_dp.sv
module wake_clk_dp
  import wake_clk_pkg::*;
#(
  parameter int STARTUP_CNT = 65536
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        xtalTick,
  input  wakeStrobe_t strobe,
  input  logic [1:0]  divReq,
  output logic        cntDone,
  output logic [1:0]  divCode
);
  localparam int CW = (STARTUP_CNT > 2) ? $clog2(STARTUP_CNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CNT - 1);

  logic [CW-1:0] cnt;

  assign cntDone = strobe.cntEn && xtalTick && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        cnt <= '0;
    else if (strobe.cntClr)           cnt <= '0;
    else if (strobe.cntEn && xtalTick) cnt <= cntDone ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  divCode <= DIV_BY1;
    else if (strobe.forceDiv1)  divCode <= DIV_BY1;
    else if (strobe.divWrEn)    divCode <= divReq;
  end
endmodule

// File: rtl/wake_clk_sel.sv
module wake_clk_sel
  import wake_clk_pkg::*;
#(
  parameter int STARTUP_CNT = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       xtalTick,
  input  logic       ringTick,
  input  logic       stopReq,
  input  logic       stopExit,
  input  logic       ringSelEn,
  input  logic       divWr,
  input  logic [1:0] divReq,
  output logic       coreTick,
  output logic       wdtTick,
  output logic       xtalOn,
  output logic       onRing,
  output logic       divLock,
  output logic [1:0] divCode
);
  wakeStrobe_t strobe;
  logic        cntDone;

  wake_clk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .ringTick(ringTick),
    .stopReq(stopReq), .stopExit(stopExit), .ringSelEn(ringSelEn),
    .divWr(divWr), .cntDone(cntDone), .strobe(strobe),
    .coreTick(coreTick), .onRing(onRing), .xtalOn(xtalOn)
  );

  wake_clk_dp #(.STARTUP_CNT(STARTUP_CNT)) dp_i (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .strobe(strobe),
    .divReq(divReq), .cntDone(cntDone), .divCode(divCode)
  );

  assign wdtTick = xtalTick && xtalOn;
  assign divLock = onRing;
endmodule

// File: rtl/wake_clk_sel_chk.sv
module wake_clk_sel_chk (
  input logic       clk,
  input logic       rstN,
  input logic       xtalTick,
  input logic       ringTick,
  input logic       coreTick,
  input logic       wdtTick,
  input logic       xtalOn,
  input logic       onRing,
  input logic [1:0] divCode
);
  // R2
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xtalOn |-> (!coreTick && !wdtTick));

  // R5
  ring_from_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(onRing) |-> $past(!xtalOn));

  // R6
  clean_handover_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(onRing) && xtalOn) |-> $past(!xtalTick && !ringTick));

  // R7
  div_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    onRing |-> (divCode == 2'b10));

  // R8
  wdt_xtal_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtTick |-> (xtalTick && xtalOn));

  // R4
  core_tick_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreTick && !onRing) |-> xtalTick);
endmodule

bind wake_clk_sel wake_clk_sel_chk chk_i (
  .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .ringTick(ringTick),
  .coreTick(coreTick), .wdtTick(wdtTick), .xtalOn(xtalOn),
  .onRing(onRing), .divCode(divCode)
);

// File: tb/wake_clk_sel_tb_top.sv
module wake_clk_sel_tb_top;
  localparam int CNT = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xtalTick = 1'b0, ringTick = 1'b0, stopReq = 1'b0, stopExit = 1'b0;
  logic ringSelEn = 1'b0, divWr = 1'b0;
  logic [1:0] divReq = 2'b00;
  logic coreTick, wdtTick, xtalOn, onRing, divLock;
  logic [1:0] divCode;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model: 0 run, 1 stopped, 2 held wait, 3 ring wait, 4 handover
  int mState = 0, mCnt = 0;
  logic [1:0] mDiv = 2'b10;

  always #5 clk = ~clk;

  wake_clk_sel #(.STARTUP_CNT(CNT)) dut_i (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .ringTick(ringTick),
    .stopReq(stopReq), .stopExit(stopExit), .ringSelEn(ringSelEn),
    .divWr(divWr), .divReq(divReq), .coreTick(coreTick), .wdtTick(wdtTick),
    .xtalOn(xtalOn), .onRing(onRing), .divLock(divLock), .divCode(divCode)
  );

  function automatic bit expRing();
    return (mState == 3) || (mState == 4);
  endfunction

  function automatic logic expCore();
    if (mState == 0) return xtalTick;
    if (expRing())   return ringTick;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState <= 0; mCnt <= 0; mDiv <= 2'b10;
    end else begin
      case (mState)
        0: begin
          if (divWr) mDiv <= divReq;                          // R10
          if (stopReq) mState <= 1;                           // R2
        end
        1: begin
          if (divWr) mDiv <= divReq;
          if (stopExit) begin                                 // R3
            mCnt <= 0;
            mState <= ringSelEn ? 3 : 2;
            if (ringSelEn) mDiv <= 2'b10;                     // R7
          end
        end
        2, 3: begin
          if (mState == 2 && divWr) mDiv <= divReq;
          if (stopReq) mState <= 1;                           // R9
          else if (xtalTick) begin
            if (mCnt == CNT - 1) begin
              mCnt <= 0;
              mState <= (mState == 2) ? 0 : 4;
            end else mCnt <= mCnt + 1;
          end
        end
        default: begin
          if (stopReq) mState <= 1;
          else if (!xtalTick && !ringTick) mState <= 0;       // R6
        end
      endcase
    end
  end

  task automatic check1(input string req, input string name, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, name, act, exp);
    end
  endtask

  task automatic checkAll();
    check1(mState == 0 ? "R4" : "R5", "coreTick", coreTick, expCore());
    check1("R8", "wdtTick", wdtTick, xtalTick && (mState != 1));
    check1("R2", "xtalOn", xtalOn, mState != 1);
    check1("R6", "onRing", onRing, expRing());
    check1("R7", "divLock", divLock, expRing());
    tests++;
    if (divCode !== mDiv) begin
      fails++;
      $display("FAIL R10 divCode actual=%0b expected=%0b", divCode, mDiv);
    end
  endtask

  task automatic drive(input logic xt, rt, sr, se, rs, dw, input logic [1:0] dr);
    @(negedge clk);
    xtalTick = xt; ringTick = rt; stopReq = sr; stopExit = se;
    ringSelEn = rs; divWr = dw; divReq = dr;
    #2 checkAll();
  endtask

  task automatic randCycles(input int n, input int rsel, input int stopOdds);
    for (int i = 0; i < n; i++) begin
      int rs;
      rs = (rsel > 1) ? int'($urandom_range(1)) : rsel;
      drive($urandom_range(1), $urandom_range(1),
            ($urandom_range(stopOdds - 1) == 0),
            ($urandom_range(7) == 0), rs[0],
            ($urandom_range(7) == 0), 2'($urandom_range(3)));
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 reset state
    drive(1, 0, 0, 0, 0, 0, 2'b00);
    drive(0, 1, 0, 0, 0, 0, 2'b00);
    rstN = 1'b1;
    drive(1, 1, 0, 0, 0, 0, 2'b00);
    check1("R1", "divCode msb", divCode[1], 1'b1);
    // R10 write in run, then R2 stop with repeated stop (ignored)
    drive(0, 0, 0, 0, 0, 1, 2'b11);
    drive(1, 0, 1, 0, 0, 0, 2'b00);
    drive(1, 1, 1, 0, 0, 0, 2'b00);
    drive(1, 1, 0, 0, 0, 0, 2'b00);
    // R4 held wake, every tick present
    drive(1, 1, 0, 1, 0, 0, 2'b00);
    for (int i = 0; i < CNT + 3; i++) drive(1, 1, 0, 0, 0, 0, 2'b00);
    // R5/R10 wake into ring with a simultaneous divide write: forced code wins
    drive(0, 0, 1, 0, 1, 0, 2'b00);
    drive(0, 0, 0, 1, 1, 1, 2'b01);
    // R7 write ignored while on ring
    drive(1, 1, 0, 0, 1, 1, 2'b00);
    // R9 stop mid-count, then fresh wake
    for (int i = 0; i < CNT / 2; i++) drive(1, 1, 0, 0, 1, 0, 2'b00);
    drive(1, 0, 1, 0, 1, 0, 2'b00);
    drive(1, 0, 0, 1, 1, 0, 2'b00);
    // R6 handover delayed while both ticks stay high
    for (int i = 0; i < CNT + 6; i++) drive(1, 1, 0, 0, 1, 0, 2'b00);
    drive(0, 0, 0, 0, 1, 0, 2'b00);
    drive(1, 0, 0, 0, 1, 0, 2'b00);
    // stopExit outside stop is ignored (R3)
    drive(1, 0, 0, 1, 1, 0, 2'b00);
    // random phases
    randCycles(4000, 0, 60);
    randCycles(4000, 1, 60);
    randCycles(6000, 2, 25);
    summary();
  end
endmodule